// File: doc/BRIEF.md
# Multi-drop serial port with nine-bit address filtering

This block is a full-duplex asynchronous serial port for a processor subsystem. It has one byte-wide control register and a pair of data paths. The control register selects the frame format: eight data bits, or nine data bits in which the extra bit marks an address frame. It also holds the receiver enable, a switch that turns on address filtering, the extra bit to send, the extra bit that was received, and two sticky completion flags. A write to the transmit data port starts a frame when the transmitter is idle. Received bytes wait in a buffer that software can read.

On a multi-drop link every listening node sets the filtering switch. Each node then wakes only on frames whose ninth bit is 1 (addresses). The node that recognises its own address clears the switch and takes the data frames that follow. The completion flags are never cleared by hardware. Writing 0 to a flag clears it and writing 1 leaves it alone. A set event in hardware always beats a software clear in the same cycle. As a result, a read-modify-write of the control register cannot erase an event. Bit timing comes from an external tick at sixteen times the bit rate.

Top module: `uart9_port`

## Requirements
- R1: After reset the control register reads 0x00, the receive buffer reads 0x00 and the serial output is high.
- R2: Control bits are, from bit 7 down: mode high, mode low, address filter enable, receive enable, transmit ninth bit, receive ninth bit, transmit done flag (bit 1), receive done flag (bit 0). Bits 7 to 2 read back exactly as written.
- R3: With mode {bit7,bit6}=01, a data write while idle sends a 0 start bit, the eight data bits LSB first and a 1 stop bit, each lasting 16 ticks. When the stop bit ends, bit 1 is set.
- R4: With mode 10 or 11, the frame carries a ninth bit between the data and the stop bit, and that bit equals control bit 3.
- R5: Writing 1 to bit 1 or bit 0 has no effect. Writing 0 clears the flag. Hardware never clears a flag.
- R6: A completion event in the same cycle as a control write leaves its flag set, whether the write carries a 1 or a 0 for that flag.
- R7: In mode 01 with receive enabled, a valid frame loads the data byte into the receive buffer, sets bit 0 and copies the stop bit (1) into bit 2.
- R8: In mode 10 or 11 with the filter off, a valid frame loads the buffer, sets bit 0 and copies its ninth bit into bit 2.
- R9: In a nine-bit mode with the filter on, a frame whose ninth bit is 0 leaves the buffer and bit 0 unchanged. A frame whose ninth bit is 1 is accepted as in R8.
- R10: A frame whose stop bit samples 0 is dropped: the buffer and bit 0 are unchanged.
- R11: With bit 4 clear, no frame is received.
- R12: In mode 00 the port neither sends nor receives: the output stays high and both flags stay clear.
- R13: A low pulse on the input that is high again at the middle of the start bit does not start a frame.
- R14: A data write while a frame is being sent is ignored, and the frame in progress goes out unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous |
| baud_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write value |
| dat_we | input | 1 | Transmit data write strobe |
| tx_data | input | DATA_W | Byte to send |
| ctl_rdata | output | 8 | Control register contents |
| rx_data | output | DATA_W | Last accepted received byte |
| rxd | input | 1 | Serial input, idles high |
| txd | output | 1 | Serial output, idles high |

## Verification
The hardest case to reach from the ports is a flag-setting event and a control write landing in the very same clock cycle. The bench drives the baud tick itself, one pulse at a time, so it knows which tick ends the transmit stop bit (tick 160 of an eight-bit frame). It raises the control write strobe together with that final tick, once with the flag bit written 1 and once with it written 0, and expects the flag set both times. Receive corner cases come from frames that the bench shapes bit by bit on the input: a stop bit that drops too early, a short start glitch, and data frames sent while the address filter is on.

// File: rtl/uart9_pkg.sv
package uart9_pkg;

    typedef enum logic [1:0] {
        MODE_OFF = 2'b00,
        MODE_8B  = 2'b01,
        MODE_9A  = 2'b10,
        MODE_9B  = 2'b11
    } uart9_mode_e;

    localparam int unsigned CTL_W      = 8;
    localparam int unsigned B_MODE_HI  = 7;
    localparam int unsigned B_MODE_LO  = 6;
    localparam int unsigned B_FILT     = 5;
    localparam int unsigned B_RXEN     = 4;
    localparam int unsigned B_TX9      = 3;
    localparam int unsigned B_RX9      = 2;
    localparam int unsigned B_TXDONE   = 1;
    localparam int unsigned B_RXDONE   = 0;

endpackage

// File: rtl/uart9_tx.sv
module uart9_tx #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              start,
    input  logic              nine,
    input  logic              bit9,
    input  logic [DATA_W-1:0] din,
    output logic              txd,
    output logic              busy,
    output logic              done
);
    localparam int unsigned FRAME_W = DATA_W + 3;
    localparam int unsigned CNT_W   = $clog2(FRAME_W + 1);
    localparam int unsigned PH_W    = $clog2(OVS);

    typedef struct packed {
        logic               busy;
        logic [FRAME_W-1:0] shreg;
        logic [CNT_W-1:0]   left;
        logic [PH_W-1:0]    phase;
    } tx_state_t;

    tx_state_t s_d, s_q;

    always_comb begin
        s_d  = s_q;
        done = 1'b0;
        if (!s_q.busy) begin
            if (start) begin
                s_d.busy  = 1'b1;
                s_d.shreg = {1'b1, (nine ? bit9 : 1'b1), din, 1'b0};
                s_d.left  = nine ? CNT_W'(FRAME_W) : CNT_W'(FRAME_W - 1);
                s_d.phase = '0;
            end
        end else if (tick) begin
            if (s_q.phase == PH_W'(OVS - 1)) begin
                s_d.phase = '0;
                s_d.shreg = {1'b1, s_q.shreg[FRAME_W-1:1]};
                s_d.left  = s_q.left - 1'b1;
                if (s_q.left == CNT_W'(1)) begin
                    s_d.busy = 1'b0;
                    done     = 1'b1;
                end
            end else begin
                s_d.phase = s_q.phase + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{busy: 1'b0, shreg: '1, left: '0, phase: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign txd  = s_q.busy ? s_q.shreg[0] : 1'b1;
    assign busy = s_q.busy;

    // R3: a frame opens with a low start bit
    a_r3_start_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.busy) |-> !txd);

    // R14: without a tick the shift register holds, whatever is written
    a_r14_hold_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && !tick) |=> $stable(s_q.shreg));

endmodule

// File: rtl/uart9_rx.sv
module uart9_rx
    import uart9_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rxd,
    input  logic              enable,
    input  logic              nine,
    output logic              frame_valid,
    output logic [DATA_W-1:0] frame_data,
    output logic              frame_bit9,
    output logic              frame_stop
);
    localparam int unsigned PH_W  = $clog2(OVS);
    localparam int unsigned HALF  = OVS / 2;
    localparam int unsigned IDX_W = $clog2(DATA_W + 1);

    typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_st_e;

    typedef struct packed {
        rx_st_e            st;
        logic [1:0]        sync;
        logic [PH_W-1:0]   phase;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W:0]   sh;
        logic              nine;
    } rx_state_t;

    rx_state_t s_d, s_q;
    logic      rx_bit;
    logic [IDX_W-1:0] last_idx;

    assign rx_bit   = s_q.sync[1];
    assign last_idx = s_q.nine ? IDX_W'(DATA_W) : IDX_W'(DATA_W - 1);

    always_comb begin
        s_d         = s_q;
        s_d.sync    = {s_q.sync[0], rxd};
        frame_valid = 1'b0;
        frame_stop  = rx_bit;
        case (s_q.st)
            RX_IDLE: begin
                if (enable && !rx_bit) begin
                    s_d.st    = RX_START;
                    s_d.phase = '0;
                    s_d.nine  = nine;
                end
            end
            RX_START: begin
                if (tick) begin
                    if (s_q.phase == PH_W'(HALF - 1)) begin
                        s_d.phase = '0;
                        s_d.idx   = '0;
                        s_d.st    = rx_bit ? RX_IDLE : RX_DATA;
                    end else begin
                        s_d.phase = s_q.phase + 1'b1;
                    end
                end
            end
            RX_DATA: begin
                if (tick) begin
                    if (s_q.phase == PH_W'(OVS - 1)) begin
                        s_d.phase = '0;
                        s_d.sh    = {rx_bit, s_q.sh[DATA_W:1]};
                        if (s_q.idx == last_idx) begin
                            s_d.st = RX_STOP;
                        end else begin
                            s_d.idx = s_q.idx + 1'b1;
                        end
                    end else begin
                        s_d.phase = s_q.phase + 1'b1;
                    end
                end
            end
            default: begin
                if (tick) begin
                    if (s_q.phase == PH_W'(OVS - 1)) begin
                        s_d.phase   = '0;
                        s_d.st      = RX_IDLE;
                        frame_valid = 1'b1;
                    end else begin
                        s_d.phase = s_q.phase + 1'b1;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: RX_IDLE, sync: 2'b11, phase: '0, idx: '0, sh: '0, nine: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign frame_data = s_q.nine ? s_q.sh[DATA_W-1:0] : s_q.sh[DATA_W:1];
    assign frame_bit9 = s_q.nine & s_q.sh[DATA_W];

    // R11: a disabled receiver never leaves idle
    a_r11_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == RX_IDLE && !enable) |=> (s_q.st == RX_IDLE));

    // R13: a high line at mid start bit sends the receiver back to idle
    a_r13_false_start: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == RX_START && tick && s_q.phase == PH_W'(HALF - 1) && rx_bit)
        |=> (s_q.st == RX_IDLE));

endmodule

// File: rtl/uart9_regs.sv
module uart9_regs
    import uart9_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_we,
    input  logic [CTL_W-1:0]  ctl_wdata,
    input  logic              tx_done,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_frame_data,
    input  logic              rx_frame_bit9,
    input  logic              rx_frame_stop,
    output logic [CTL_W-1:0]  ctl_q,
    output logic [DATA_W-1:0] rx_buf
);
    typedef struct packed {
        logic [CTL_W-1:0]  ctl;
        logic [DATA_W-1:0] rbuf;
    } reg_state_t;

    reg_state_t s_d, s_q;
    logic       nine;
    logic       accept;
    logic       clr_tx, clr_rx;

    assign nine   = s_q.ctl[B_MODE_HI];
    assign accept = rx_valid && rx_frame_stop
                    && !(nine && s_q.ctl[B_FILT] && !rx_frame_bit9);
    assign clr_tx = ctl_we && !ctl_wdata[B_TXDONE];
    assign clr_rx = ctl_we && !ctl_wdata[B_RXDONE];

    always_comb begin
        s_d = s_q;
        if (ctl_we) begin
            s_d.ctl[CTL_W-1:B_RX9] = ctl_wdata[CTL_W-1:B_RX9];
        end
        if (accept) begin
            s_d.rbuf       = rx_frame_data;
            s_d.ctl[B_RX9] = nine ? rx_frame_bit9 : rx_frame_stop;
        end
        s_d.ctl[B_TXDONE] = tx_done | (s_q.ctl[B_TXDONE] & ~clr_tx);
        s_d.ctl[B_RXDONE] = accept  | (s_q.ctl[B_RXDONE] & ~clr_rx);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ctl_q  = s_q.ctl;
    assign rx_buf = s_q.rbuf;

    // R5: a set flag survives anything but a written zero
    a_r5_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q[B_TXDONE] && !(ctl_we && !ctl_wdata[B_TXDONE])) |=> ctl_q[B_TXDONE]);

    // R6: a transmit completion is never lost to a simultaneous write
    a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |=> ctl_q[B_TXDONE]);

    // R9: filtered data frames leave the receive flag clear
    a_r9_filter_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && ctl_q[B_MODE_HI] && ctl_q[B_FILT] && !rx_frame_bit9
         && !ctl_q[B_RXDONE] && !ctl_we) |=> !ctl_q[B_RXDONE]);

    // R10: a frame with a low stop bit does not touch the buffer
    a_r10_bad_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_frame_stop) |=> $stable(rx_buf));

    // R7: the buffer only changes when a frame completes
    a_r7_buf_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |=> $stable(rx_buf));

endmodule

// File: rtl/uart9_port.sv
module uart9_port
    import uart9_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              ctl_we,
    input  logic [7:0]        ctl_wdata,
    input  logic              dat_we,
    input  logic [DATA_W-1:0] tx_data,
    output logic [7:0]        ctl_rdata,
    output logic [DATA_W-1:0] rx_data,
    input  logic              rxd,
    output logic              txd
);
    logic [CTL_W-1:0]  ctl;
    logic              port_on;
    logic              tx_busy, tx_done;
    logic              rx_valid, rx_bit9, rx_stop;
    logic [DATA_W-1:0] rx_frame;

    assign port_on = (uart9_mode_e'(ctl[B_MODE_HI:B_MODE_LO]) != MODE_OFF);

    uart9_tx #(.DATA_W(DATA_W), .OVS(OVS)) tx_i (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (baud_tick),
        .start (dat_we && port_on),
        .nine  (ctl[B_MODE_HI]),
        .bit9  (ctl[B_TX9]),
        .din   (tx_data),
        .txd   (txd),
        .busy  (tx_busy),
        .done  (tx_done)
    );

    uart9_rx #(.DATA_W(DATA_W), .OVS(OVS)) rx_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (baud_tick),
        .rxd         (rxd),
        .enable      (ctl[B_RXEN] && port_on),
        .nine        (ctl[B_MODE_HI]),
        .frame_valid (rx_valid),
        .frame_data  (rx_frame),
        .frame_bit9  (rx_bit9),
        .frame_stop  (rx_stop)
    );

    uart9_regs #(.DATA_W(DATA_W)) regs_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .ctl_we        (ctl_we),
        .ctl_wdata     (ctl_wdata),
        .tx_done       (tx_done),
        .rx_valid      (rx_valid),
        .rx_frame_data (rx_frame),
        .rx_frame_bit9 (rx_bit9),
        .rx_frame_stop (rx_stop),
        .ctl_q         (ctl),
        .rx_buf        (rx_data)
    );

    assign ctl_rdata = ctl;

    // R12: with the port off and nothing in flight the line stays high
    a_r12_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!port_on && !tx_busy && !ctl_we) |=> txd);

endmodule

// File: tb/uart9_port_tb.sv
`timescale 1ns/1ps
module uart9_port_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic       ctl_we = 1'b0;
    logic [7:0] ctl_wdata = '0;
    logic       dat_we = 1'b0;
    logic [7:0] tx_data = '0;
    logic [7:0] ctl_rdata;
    logic [7:0] rx_data;
    logic       rxd = 1'b1;
    logic       txd;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] last_rx = 8'h00;

    always #4 clk = ~clk;

    uart9_port dut_i (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
        .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .dat_we(dat_we), .tx_data(tx_data),
        .ctl_rdata(ctl_rdata), .rx_data(rx_data),
        .rxd(rxd), .txd(txd)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wr_ctl(input logic [7:0] v);
        @(negedge clk); ctl_we = 1'b1; ctl_wdata = v;
        @(negedge clk); ctl_we = 1'b0;
    endtask

    task automatic wr_dat(input logic [7:0] v);
        @(negedge clk); dat_we = 1'b1; tx_data = v;
        @(negedge clk); dat_we = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); baud_tick = 1'b1;
            @(negedge clk); baud_tick = 1'b0;
        end
    endtask

    task automatic line_bit(input logic v, input int n);
        @(negedge clk); rxd = v;
        ticks(n);
    endtask

    task automatic send_rx(input logic [7:0] d, input logic nine,
                           input logic b9, input logic stop);
        line_bit(1'b0, 16);
        for (int i = 0; i < 8; i++) line_bit(d[i], 16);
        if (nine) line_bit(b9, 16);
        if (stop) begin
            line_bit(1'b1, 16);
        end else begin
            line_bit(1'b0, 12);
            line_bit(1'b1, 24);
        end
        ticks(4);
    endtask

    task automatic tx_frame(input string req, input logic [7:0] d,
                            input logic nine, input logic b9, input logic poke);
        logic [10:0] exp_bits;
        int nb;
        nb = nine ? 11 : 10;
        exp_bits = {1'b1, (nine ? b9 : 1'b1), d, 1'b0};
        wr_dat(d);
        for (int b = 0; b < nb; b++) begin
            ticks(8);
            chk(req, $sformatf("tx bit %0d", b), 32'(txd), 32'(exp_bits[b]));
            if (poke && b == 3) wr_dat(~d);
            ticks(8);
        end
    endtask

    task automatic t_reset;
        chk("R1", "ctl after reset", 32'(ctl_rdata), 32'h00);
        chk("R1", "rx buffer after reset", 32'(rx_data), 32'h00);
        chk("R1", "txd after reset", 32'(txd), 32'h1);
    endtask

    task automatic t_regs;
        wr_ctl(8'hF8);
        chk("R2", "readback F8", 32'(ctl_rdata), 32'hF8);
        wr_ctl(8'h7C);
        chk("R2", "readback 7C", 32'(ctl_rdata), 32'h7C);
        wr_ctl(8'h03);
        chk("R5", "writing ones to flags", 32'(ctl_rdata), 32'h00);
    endtask

    task automatic t_tx8;
        wr_ctl(8'h48);
        tx_frame("R3", 8'hA5, 1'b0, 1'b0, 1'b0);
        chk("R3", "tx done set", 32'(ctl_rdata), 32'h4A);
        chk("R3", "line idle after frame", 32'(txd), 32'h1);
        ticks(20);
        wr_ctl(8'h4A);
        chk("R5", "flag kept by written one", 32'(ctl_rdata), 32'h4A);
        wr_ctl(8'h48);
        chk("R5", "flag cleared by written zero", 32'(ctl_rdata), 32'h48);
        tx_frame("R14", 8'h3C, 1'b0, 1'b0, 1'b1);
        ticks(20);
        chk("R14", "line idle, no second frame", 32'(txd), 32'h1);
    endtask

    task automatic t_tx9;
        wr_ctl(8'h88);
        tx_frame("R4", 8'h3C, 1'b1, 1'b1, 1'b0);
        chk("R4", "done after nine-bit frame", 32'(ctl_rdata), 32'h8A);
        wr_ctl(8'hC0);
        tx_frame("R4", 8'h81, 1'b1, 1'b0, 1'b0);
        chk("R4", "done after mode 11 frame", 32'(ctl_rdata), 32'hC2);
    endtask

    task automatic t_collide(input logic [7:0] wv);
        wr_ctl(8'h40);
        wr_dat(8'h55);
        ticks(159);
        @(negedge clk); baud_tick = 1'b1; ctl_we = 1'b1; ctl_wdata = wv;
        @(negedge clk); baud_tick = 1'b0; ctl_we = 1'b0;
        chk("R6", $sformatf("flag with write %0h on final tick", wv),
            32'(ctl_rdata), 32'h42);
    endtask

    task automatic t_rx8;
        wr_ctl(8'h50);
        send_rx(8'h5A, 1'b0, 1'b0, 1'b1);
        last_rx = 8'h5A;
        chk("R7", "rx data", 32'(rx_data), 32'(last_rx));
        chk("R7", "ctl after rx", 32'(ctl_rdata), 32'h55);
        wr_ctl(8'h54);
        chk("R5", "rx flag cleared", 32'(ctl_rdata), 32'h54);
    endtask

    task automatic t_rx9;
        wr_ctl(8'h90);
        send_rx(8'h3C, 1'b1, 1'b0, 1'b1);
        chk("R8", "rx data ninth 0", 32'(rx_data), 32'h3C);
        chk("R8", "ctl ninth 0", 32'(ctl_rdata), 32'h91);
        wr_ctl(8'h90);
        send_rx(8'hC3, 1'b1, 1'b1, 1'b1);
        last_rx = 8'hC3;
        chk("R8", "rx data ninth 1", 32'(rx_data), 32'(last_rx));
        chk("R8", "ctl ninth 1", 32'(ctl_rdata), 32'h95);
    endtask

    task automatic t_filter;
        wr_ctl(8'hB0);
        send_rx(8'h11, 1'b1, 1'b0, 1'b1);
        chk("R9", "data frame dropped, ctl", 32'(ctl_rdata), 32'hB0);
        chk("R9", "data frame dropped, buffer", 32'(rx_data), 32'(last_rx));
        send_rx(8'h22, 1'b1, 1'b1, 1'b1);
        last_rx = 8'h22;
        chk("R9", "address frame taken, ctl", 32'(ctl_rdata), 32'hB5);
        chk("R9", "address frame taken, buffer", 32'(rx_data), 32'(last_rx));
        wr_ctl(8'h90);
        send_rx(8'h33, 1'b1, 1'b0, 1'b1);
        last_rx = 8'h33;
        chk("R9", "data after filter off", 32'(rx_data), 32'(last_rx));
        chk("R9", "ctl after filter off", 32'(ctl_rdata), 32'h91);
    endtask

    task automatic t_badstop;
        wr_ctl(8'h50);
        send_rx(8'h77, 1'b0, 1'b0, 1'b0);
        chk("R10", "ctl after low stop", 32'(ctl_rdata), 32'h50);
        chk("R10", "buffer after low stop", 32'(rx_data), 32'(last_rx));
    endtask

    task automatic t_glitch;
        wr_ctl(8'h50);
        line_bit(1'b0, 4);
        line_bit(1'b1, 30);
        chk("R13", "ctl after glitch", 32'(ctl_rdata), 32'h50);
        chk("R13", "buffer after glitch", 32'(rx_data), 32'(last_rx));
        send_rx(8'h96, 1'b0, 1'b0, 1'b1);
        last_rx = 8'h96;
        chk("R13", "frame after glitch", 32'(rx_data), 32'(last_rx));
    endtask

    task automatic t_rx_off;
        wr_ctl(8'h40);
        send_rx(8'h12, 1'b0, 1'b0, 1'b1);
        chk("R11", "ctl with receiver off", 32'(ctl_rdata), 32'h40);
        chk("R11", "buffer with receiver off", 32'(rx_data), 32'(last_rx));
    endtask

    task automatic t_off;
        logic seen_low;
        seen_low = 1'b0;
        wr_ctl(8'h10);
        wr_dat(8'h00);
        for (int i = 0; i < 200; i++) begin
            ticks(1);
            if (!txd) seen_low = 1'b1;
        end
        chk("R12", "txd never low in mode 00", 32'(seen_low), 32'h0);
        send_rx(8'hE7, 1'b0, 1'b0, 1'b1);
        chk("R12", "ctl in mode 00", 32'(ctl_rdata), 32'h10);
        chk("R12", "buffer in mode 00", 32'(rx_data), 32'(last_rx));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_tx8();
        t_tx9();
        t_collide(8'h42);
        t_collide(8'h40);
        t_rx8();
        t_rx9();
        t_filter();
        t_badstop();
        t_glitch();
        t_rx_off();
        t_off();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule